// File: doc/BRIEF.md
# Timed Stereo Sample Register Interface

This block is the register front end that delivers the output of a stereo resampler to software. An interval timer, with its period set by a 12-bit rate field, produces sample events. At each event the block captures one 24-bit sample per channel from a parallel upstream source and holds it in data registers. It then updates per-channel "new data" flags and a sticky overrun flag, and pulses an interrupt request.

Software reaches the block over a small 16-bit register bus. The bus has an address, separate read and write strobes, write data, and a combinational read-data return. Each channel's sample is split into a high word and a low word. Reading the high word acknowledges the sample. After each enable, a start-up tracker raises a valid output once enough events have passed for the upstream filter to have settled.

Top module: `stereo_sample_regs`

## Requirements
- R1: Offset 0 is the configuration word: bit 15 overrun, bit 14 right-full, bit 13 left-full, bit 12 enable, bits 11:0 rate. Enable and rate read back the last value written.
- R2: While enabled, a sample event occurs every 2·(rate+1) clocks. When enable is written to 1, the first interrupt is seen exactly 2·(rate+1) cycles after the first cycle in which enable reads back 1 (for example, 4096 cycles for rate 0x7FF).
- R3: No event occurs while enable is 0. Clearing enable resets the interval count, so re-enabling starts a full period again.
- R4: An event captures both 24-bit inputs as they stand in the event cycle. Offset 1 reads left bits 23:8, offset 2 reads left bits 7:0 in bits 7:0 with zeros above, offset 3 reads right bits 23:8, and offset 4 reads right bits 7:0 in the same way. Other offsets read 0.
- R5: A channel's full flag is set by each event and is cleared by a read strobe to that channel's high word (offset 1 or 3). A read in the same cycle as an event leaves the flag set. Reading a low word leaves the flag unchanged.
- R6: The overrun flag is set when an event occurs while either full flag is 1. It stays set through configuration writes with bit 15 at 1. A configuration write with bit 15 at 0 clears it, unless an event in the same cycle sets it.
- R7: The interrupt is a one-cycle pulse per event, high in the first cycle in which the new samples are readable.
- R8: `out_valid` is 1 only while enabled and after 19 events since the last enable. It rises together with the 19th interrupt and drops in the first cycle that enable reads back 0.
- R9: Write data in bits 14:13 of the configuration word has no effect, and writes to offsets 1 to 4 change nothing.
- R10: After reset every register reads 0, and `irq` and `out_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, used to acknowledge high words |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| src_left | input | 24 | Upstream left sample |
| src_right | input | 24 | Upstream right sample |
| irq | output | 1 | Interrupt pulse per stored sample pair |
| out_valid | output | 1 | Start-up settling done |

## Verification
Each result has a known delay after its stimulus:
- A configuration write takes effect on the next edge, so enable and rate read back one cycle later.
- An event cycle is followed one edge later by the interrupt, the new data, the set full flags, any overrun, and the 19th-event valid.
- A read strobe clears its full flag on the edge that closes the strobe cycle.
- Read data is combinational on the offset.

A behavioural model in the bench takes the same inputs at every rising edge. The bench compares `irq`, `out_valid` and the read data against the model a quarter period after that edge, when all of these delays have settled. Directed checks count cycles from the write that sets enable to the interrupt, and between interrupts, against 2·(rate+1).

// File: rtl/ssr_pkg.sv
package ssr_pkg;

  // register offsets
  localparam int unsigned OFS_CFG      = 0;
  localparam int unsigned OFS_LEFT_HI  = 1;
  localparam int unsigned OFS_LEFT_LO  = 2;
  localparam int unsigned OFS_RIGHT_HI = 3;
  localparam int unsigned OFS_RIGHT_LO = 4;

  // configuration word bit positions
  localparam int unsigned CFG_ORUN_BIT  = 15;
  localparam int unsigned CFG_RFULL_BIT = 14;
  localparam int unsigned CFG_LFULL_BIT = 13;
  localparam int unsigned CFG_EN_BIT    = 12;

  // event spacing in clocks for a given rate code
  function automatic int unsigned period_clocks(input int unsigned rate);
    return 2 * (rate + 1);
  endfunction

endpackage

// File: rtl/ssr_interval_timer.sv
module ssr_interval_timer #(
  parameter int unsigned RATE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);
  localparam int unsigned CNT_W = RATE_W + 2;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;

  // last count value of a period; >= keeps a rate cut mid-period bounded
  always_comb last = CNT_W'(ssr_pkg::period_clocks(32'(rate)) - 1);
  assign tick = enable && (cnt >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!enable) cnt <= '0;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

  // R3: the period is at least two clocks, so a disabled cycle is never followed by an event
  p_quiet_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !tick);

endmodule

// File: rtl/ssr_startup_tracker.sv
module ssr_startup_tracker #(
  parameter int unsigned SETTLE_EVENTS = 19
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic tick,
  output logic valid
);
  localparam int unsigned CW = $clog2(SETTLE_EVENTS + 1);
  localparam logic [CW-1:0] FULL_COUNT = CW'(SETTLE_EVENTS);

  logic [CW-1:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          seen <= '0;
    else if (!enable)                    seen <= '0;
    else if (tick && seen != FULL_COUNT) seen <= seen + 1'b1;
  end

  assign valid = enable && (seen == FULL_COUNT);

endmodule

// File: rtl/ssr_channel_reg.sv
module ssr_channel_reg #(
  parameter int unsigned SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic [SAMPLE_W-1:0] sample_in,
  input  logic                ack_rd,
  output logic [SAMPLE_W-1:0] sample_q,
  output logic                full,
  output logic                overrun_hit
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sample_q <= '0;
    else if (tick) sample_q <= sample_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      full <= 1'b0;
    else if (tick)   full <= 1'b1;
    else if (ack_rd) full <= 1'b0;
  end

  // new data arriving on a sample not yet acknowledged
  assign overrun_hit = tick && full;

  // R5: an acknowledge without a competing event empties the channel
  p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && !tick) |=> !full);

  // R4: the stored word is the input seen in the event cycle
  p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (sample_q == $past(sample_in)));

endmodule

// File: rtl/stereo_sample_regs.sv
module stereo_sample_regs #(
  parameter int unsigned ADDR_W        = 3,
  parameter int unsigned DATA_W        = 16,
  parameter int unsigned SAMPLE_W      = 24,
  parameter int unsigned RATE_W        = 12,
  parameter int unsigned SETTLE_EVENTS = 19
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [SAMPLE_W-1:0] src_left,
  input  logic [SAMPLE_W-1:0] src_right,
  output logic                irq,
  output logic                out_valid
);
  import ssr_pkg::*;

  localparam int unsigned LO_W  = SAMPLE_W - DATA_W;
  localparam int unsigned N_CH  = 2;

  logic              cfg_en;
  logic [RATE_W-1:0] cfg_rate;
  logic              orun;

  // named internal events
  logic cfg_wr_ev;
  logic orun_clr_ev;
  logic sample_ev;
  logic any_overrun_ev;

  logic [SAMPLE_W-1:0] ch_in   [N_CH];
  logic [SAMPLE_W-1:0] ch_q    [N_CH];
  logic [N_CH-1:0]     ch_full;
  logic [N_CH-1:0]     ch_hit;
  logic [N_CH-1:0]     ch_ack;

  assign cfg_wr_ev   = bus_wr && (bus_addr == ADDR_W'(OFS_CFG));
  assign orun_clr_ev = cfg_wr_ev && !bus_wdata[CFG_ORUN_BIT];

  assign ch_in[0]  = src_left;
  assign ch_in[1]  = src_right;
  assign ch_ack[0] = bus_rd && (bus_addr == ADDR_W'(OFS_LEFT_HI));
  assign ch_ack[1] = bus_rd && (bus_addr == ADDR_W'(OFS_RIGHT_HI));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_en   <= 1'b0;
      cfg_rate <= '0;
    end else if (cfg_wr_ev) begin
      cfg_en   <= bus_wdata[CFG_EN_BIT];
      cfg_rate <= bus_wdata[RATE_W-1:0];
    end
  end

  ssr_interval_timer #(.RATE_W(RATE_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (cfg_en),
    .rate   (cfg_rate),
    .tick   (sample_ev)
  );

  ssr_startup_tracker #(.SETTLE_EVENTS(SETTLE_EVENTS)) u_settle (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (cfg_en),
    .tick   (sample_ev),
    .valid  (out_valid)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    ssr_channel_reg #(.SAMPLE_W(SAMPLE_W)) u_ch (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (sample_ev),
      .sample_in   (ch_in[c]),
      .ack_rd      (ch_ack[c]),
      .sample_q    (ch_q[c]),
      .full        (ch_full[c]),
      .overrun_hit (ch_hit[c])
    );
  end

  assign any_overrun_ev = |ch_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              orun <= 1'b0;
    else if (any_overrun_ev) orun <= 1'b1;
    else if (orun_clr_ev)    orun <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= sample_ev;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(OFS_CFG): begin
        bus_rdata[CFG_ORUN_BIT]  = orun;
        bus_rdata[CFG_RFULL_BIT] = ch_full[1];
        bus_rdata[CFG_LFULL_BIT] = ch_full[0];
        bus_rdata[CFG_EN_BIT]    = cfg_en;
        bus_rdata[RATE_W-1:0]    = cfg_rate;
      end
      ADDR_W'(OFS_LEFT_HI):  bus_rdata = ch_q[0][SAMPLE_W-1:LO_W];
      ADDR_W'(OFS_LEFT_LO):  bus_rdata = DATA_W'(ch_q[0][LO_W-1:0]);
      ADDR_W'(OFS_RIGHT_HI): bus_rdata = ch_q[1][SAMPLE_W-1:LO_W];
      ADDR_W'(OFS_RIGHT_LO): bus_rdata = DATA_W'(ch_q[1][LO_W-1:0]);
      default:               bus_rdata = '0;
    endcase
  end

  // R7: events are at least two clocks apart, so the request never lasts two cycles
  p_irq_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R5: when the request is seen both channels hold unacknowledged data
  p_irq_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (&ch_full));

  // R6: overrun survives every cycle without a clearing write
  p_orun_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (orun && !orun_clr_ev) |=> orun);

  // R8: settling completes only together with an interrupt
  p_valid_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> irq);

endmodule

// File: tb/test_stereo_sample_regs.sv
module test_stereo_sample_regs;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [23:0] src_left = 24'h123456;
  logic [23:0] src_right = 24'hABCDEF;
  logic        irq, out_valid;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  // behavioural reference state
  int          m_en, m_rate, m_cnt, m_events;
  int          m_lfull, m_rfull, m_orun, m_irq;
  logic [23:0] m_l, m_r;

  always #(CLK_P/2) clk = ~clk;

  stereo_sample_regs i_stereo_sample_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_left(src_left), .src_right(src_right), .irq(irq), .out_valid(out_valid)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] model_read(input logic [2:0] a);
    case (a)
      3'd0: return {m_orun[0], m_rfull[0], m_lfull[0], m_en[0], 12'(m_rate)};
      3'd1: return m_l[23:8];
      3'd2: return {8'h00, m_l[7:0]};
      3'd3: return m_r[23:8];
      3'd4: return {8'h00, m_r[7:0]};
      default: return 16'h0000;
    endcase
  endfunction

  // upstream source changes every cycle
  always @(negedge clk) begin
    src_left  <= src_left + 24'h013579;
    src_right <= src_right ^ {src_left[15:0], 8'hA5};
  end

  // reference update at each edge, comparison a quarter period later
  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_rate = 0; m_cnt = 0; m_events = 0;
      m_lfull = 0; m_rfull = 0; m_orun = 0; m_irq = 0; m_l = '0; m_r = '0;
    end else begin
      bit ev, hit;
      ev  = (m_en != 0) && (m_cnt >= 2 * (m_rate + 1) - 1);
      hit = ev && (m_lfull != 0 || m_rfull != 0);
      m_irq = ev;
      if (m_en == 0) m_cnt = 0; else if (ev) m_cnt = 0; else m_cnt++;
      if (m_en == 0) m_events = 0; else if (ev && m_events < 19) m_events++;
      if (ev) begin m_l = src_left; m_r = src_right; end
      if (ev) m_lfull = 1; else if (bus_rd && bus_addr == 3'd1) m_lfull = 0;
      if (ev) m_rfull = 1; else if (bus_rd && bus_addr == 3'd3) m_rfull = 0;
      if (hit) m_orun = 1; else if (bus_wr && bus_addr == 3'd0 && !bus_wdata[15]) m_orun = 0;
      if (bus_wr && bus_addr == 3'd0) begin
        m_en = int'(bus_wdata[12]);
        m_rate = int'(bus_wdata[11:0]);
      end
    end
    #(CLK_P/4);
    if (rst_n && !done) begin
      chk("R7 irq vs model", 32'(irq), 32'(m_irq));
      chk("R8 out_valid vs model", 32'(out_valid), 32'((m_en != 0) && (m_events == 19)));
      chk("R4 read data vs model", 32'(bus_rdata), 32'(model_read(bus_addr)));
    end
  end

  task automatic cfg_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic read_word(input logic [2:0] a, input bit strobe, output logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_rd = strobe;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic cycles_to_irq(output int n);
    n = 0;
    do begin
      @(posedge clk); #(CLK_P/4); n++;
    end while (!irq && n < 20000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    int n, irqs;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R10: everything clear after reset
    for (int a = 0; a < 5; a++) begin
      read_word(3'(a), 1'b0, d);
      chk("R10 reset register value", 32'(d), 32'h0);
    end
    chk("R10 reset irq/out_valid", {30'h0, irq, out_valid}, 32'h0);

    // R2 / R1: rate 0, period 2
    cfg_write(3'd0, 16'h1000);
    read_word(3'd0, 1'b0, d);
    chk("R1 enable/rate readback", 32'(d & 16'h1FFF), 32'h1000);
    cycles_to_irq(n);
    chk("R7 irq gap rate 0", 32'(n), 32'd2);

    // no reads: flags saturate, overrun sets, valid after 19 events
    repeat (45) @(negedge clk);
    chk("R8 valid after settle", 32'(out_valid), 32'd1);
    read_word(3'd0, 1'b0, d);
    chk("R6 overrun and R5 full flags", 32'(d[15:13]), 32'h7);

    // disable, keep overrun (bit 15 written 1)
    cfg_write(3'd0, 16'h8000);
    chk("R8 valid drops with enable", 32'(out_valid), 32'd0);
    read_word(3'd0, 1'b0, d);
    chk("R6 overrun sticky, R1 layout", 32'(d), 32'hE000);

    // R5: low-word read keeps the flag, high-word read clears it
    read_word(3'd2, 1'b1, d);
    chk("R4 left low word", 32'(d), 32'({8'h00, m_l[7:0]}));
    read_word(3'd0, 1'b0, d);
    chk("R5 low read keeps left full", 32'(d[13]), 32'd1);
    read_word(3'd1, 1'b1, d);
    chk("R4 left high word", 32'(d), 32'(m_l[23:8]));
    read_word(3'd0, 1'b0, d);
    chk("R5 high read clears left full only", 32'(d[14:13]), 32'h2);

    // R9 / R6: bits 14:13 ignored, bit 15 at 0 clears overrun
    cfg_write(3'd0, 16'h6000);
    read_word(3'd0, 1'b0, d);
    chk("R9 R6 flags after write 0x6000", 32'(d), 32'h4000);
    read_word(3'd3, 1'b0, d);
    cfg_write(3'd3, 16'h0F0F);
    begin
      logic [15:0] d2;
      read_word(3'd3, 1'b0, d2);
      chk("R9 data register write ignored", 32'(d2), 32'(d));
    end
    read_word(3'd6, 1'b0, d);
    chk("R4 unused offset reads zero", 32'(d), 32'h0);

    // R3: silence while disabled
    irqs = 0;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); #(CLK_P/4); if (irq) irqs++;
    end
    chk("R3 no events while disabled", 32'(irqs), 32'd0);

    // R2: rate 5 -> 12 clocks, restart after a disable mid-period
    cfg_write(3'd0, 16'h1005);
    cycles_to_irq(n);
    chk("R2 first event rate 5", 32'(n), 32'd12);
    repeat (5) @(negedge clk);
    cfg_write(3'd0, 16'h0005);
    cfg_write(3'd0, 16'h1005);
    cycles_to_irq(n);
    chk("R3 full period after re-enable", 32'(n), 32'd12);
    cycles_to_irq(n);
    chk("R2 steady gap rate 5", 32'(n), 32'd12);
    read_word(3'd3, 1'b0, d);
    chk("R4 right high word", 32'(d), 32'(m_r[23:8]));

    // R2 boundaries: 0x7FF and 0xFFF
    cfg_write(3'd0, 16'h0000);
    cfg_write(3'd0, 16'h17FF);
    cycles_to_irq(n);
    chk("R2 first event rate 0x7FF", 32'(n), 32'd4096);
    cfg_write(3'd0, 16'h0000);
    cfg_write(3'd0, 16'h1FFF);
    cycles_to_irq(n);
    chk("R2 first event rate 0xFFF", 32'(n), 32'd8192);
    cycles_to_irq(n);
    chk("R2 steady gap rate 0xFFF", 32'(n), 32'd8192);

    repeat (3) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule